// File: doc/BRIEF.md
# Interrupt Message Router

This block turns edges on a set of interrupt input pins into delivery messages for a group of eight processor agents. Each pin has its own routing entry. The entry carries a vector, a delivery mode, an addressing mode, a destination byte, polarity and trigger flags, and a mask bit. When a pin rises, the block records the event. When the output slot is free, it reads the pin's entry, resolves the destination into a target bitmask over the agents, and presents the message on a valid/ready output.

Two addressing schemes are supported. Physical addressing picks one agent by identifier, or all agents through a broadcast value. Logical addressing matches the destination byte against each agent's logical-destination byte. In the lowest-priority delivery mode the block does not use agent priorities. It narrows the logical matches to a single agent with a rotating counter that persists between events. Lowest-priority delivery in physical mode is not supported and produces an error pulse instead of a message. The external-interrupt mode takes its vector from an external legacy controller input rather than from the entry.

Top module: `irq_msg_router`

## Requirements
- R1: A pin causes an event only when it is sampled high on a clock edge after being sampled low (reset counts as low). A pin held high causes no further events, and it must be sampled low again before it can cause another one.
- R2: If the mask bit (entry bit 14) is set when the pin's rise is sampled, the event is discarded and no message and no error are produced for it.
- R3: When the mode field (entry bits 10:8) equals 3'b111 (external interrupt), the message vector is the value of `ext_vector` on the edge the message is loaded. For every other mode it is the entry vector (bits 7:0).
- R4: The message copies these fields from the entry: mode (bits 10:8), addressing flag (bit 11, 1 = logical), level from the polarity bit (bit 12), trigger (bit 13) and destination (bits 22:15). Entry p sits at `route_tbl[p*23 +: 23]`.
- R5: With the addressing flag at 0, destination 8'hFF targets all eight agents. A destination below 8 targets only agent d, whose identifier is its index. Any other destination gives an empty target mask, and the message is still sent.
- R6: With the addressing flag at 1 and a mode other than 3'b001, agent i is targeted exactly when `agent_ldest[i*8 +: 8]` ANDed with the destination is nonzero.
- R7: With mode 3'b001 (lowest priority) and logical addressing, suppose k agents match under R6 and k > 0. The message then targets only the matched agent at position (counter mod k), counting the matches in ascending index order, and the 8-bit counter then increments, wrapping from 255 to 0. With no match the target mask is empty, the message is still sent, and the counter is unchanged.
- R8: With mode 3'b001 and physical addressing, no message is sent. Instead `lp_err` is high for one cycle, in the cycle where the message would have appeared, and the event is consumed.
- R9: When several pins have events waiting, the lowest-numbered one is serviced first. The others stay pending and are serviced one per cycle while the output slot is free.
- R10: Suppose a pin is sampled high at edge N after being low, and the output slot is free at edge N+1. Then `msg_valid` is high after edge N+1. The slot is free when `msg_valid` is low or `msg_ready` is high. While `msg_valid` is high and `msg_ready` is low, all message outputs hold their values.
- R11: After reset, `msg_valid` and `lp_err` are low, no event is pending, and the rotation counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pins | input | NUM_PINS | Interrupt input pins, active high |
| route_tbl | input | NUM_PINS*23 | Routing entries, one 23-bit entry per pin |
| agent_ldest | input | 64 | Logical-destination byte of each of the 8 agents |
| ext_vector | input | 8 | Vector from the external legacy controller |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_valid | output | 1 | Message present |
| msg_targets | output | 8 | Target agent bitmask |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Addressing flag, 1 = logical |
| msg_level | output | 1 | Level field (from polarity) |
| msg_trigger | output | 1 | Trigger field |
| msg_dest | output | 8 | Destination byte |
| lp_err | output | 1 | Physical lowest-priority error pulse |

## Verification
The bench builds the router with NUM_PINS = 4. This makes it practical to sweep every pin across every addressing mode, several delivery modes, and destinations at the broadcast value, at valid identifiers, above the agent range and at zero. The small pin count also lets the bench place simultaneous rises and backpressure on neighbouring pins. More than 256 lowest-priority events are sent, so the 8-bit rotation counter is carried through its wrap with match counts that do not divide 256. The bench checks the wrapped selections against its own count of matches.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int AGENTS  = 8;
  localparam int DEST_W  = 8;
  localparam int VEC_W   = 8;
  localparam int ROT_W   = 8;
  localparam int CNT_W   = $clog2(AGENTS) + 1;
  localparam int ENTRY_W = DEST_W + 4 + 3 + VEC_W;

  localparam logic [2:0] DM_LOWPRI = 3'b001;
  localparam logic [2:0] DM_EXTVEC = 3'b111;
  localparam logic [DEST_W-1:0] DEST_ALL = '1;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trigger;
    logic              level;
    logic              logical;
    logic [2:0]        mode;
    logic [VEC_W-1:0]  vector;
  } route_entry_t;

  function automatic logic [CNT_W-1:0] count_hits(input logic [AGENTS-1:0] m);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < AGENTS; i++) n = n + CNT_W'(m[i]);
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] rot_slot(input logic [ROT_W-1:0] c,
                                                 input logic [CNT_W-1:0] k);
    logic [ROT_W-1:0] r;
    if (k == '0) return '0;
    r = c % ROT_W'(k);
    return r[CNT_W-1:0];
  endfunction

  function automatic logic [AGENTS-1:0] pick_nth(input logic [AGENTS-1:0] m,
                                                 input logic [CNT_W-1:0] n);
    logic [AGENTS-1:0] p;
    logic [CNT_W-1:0]  seen;
    p = '0;
    seen = '0;
    for (int i = 0; i < AGENTS; i++) begin
      if (m[i]) begin
        if (seen == n) p[i] = 1'b1;
        seen = seen + 1'b1;
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture #(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins,
  input  logic [NUM_PINS-1:0] mask_bits,
  input  logic [NUM_PINS-1:0] clear_vec,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] pending
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic prev_q;
    logic pend_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        prev_q <= pins[g];
        pend_q <= (pend_q & ~clear_vec[g]) | (rise[g] & ~mask_bits[g]);
      end
    end
    assign rise[g]    = pins[g] & ~prev_q;
    assign pending[g] = pend_q;
  end
endmodule

// File: rtl/irq_pin_select.sv
module irq_pin_select #(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] pending,
  output logic                any,
  output logic [PIN_W-1:0]    idx,
  output logic [NUM_PINS-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pending[i]) idx = PIN_W'(i);
    end
  end
  assign any    = |pending;
  assign onehot = pending & (~pending + 1'b1);
endmodule

// File: rtl/irq_dest_resolve.sv
module irq_dest_resolve
  import irq_route_pkg::*;
(
  input  logic [DEST_W-1:0]        dest,
  input  logic [2:0]               mode,
  input  logic                     logical,
  input  logic [AGENTS*DEST_W-1:0] agent_ldest,
  input  logic [ROT_W-1:0]         rot_cnt,
  output logic [AGENTS-1:0]        targets,
  output logic                     phys_lp_err,
  output logic                     rot_advance
);
  logic [AGENTS-1:0] lmatch;
  logic [AGENTS-1:0] pmatch;
  logic [CNT_W-1:0]  hits;

  for (genvar a = 0; a < AGENTS; a++) begin : g_agent
    assign lmatch[a] = |(agent_ldest[a*DEST_W +: DEST_W] & dest);
    assign pmatch[a] = (dest == DEST_ALL) || (dest == DEST_W'(a));
  end

  assign hits = count_hits(lmatch);

  always_comb begin
    targets     = '0;
    phys_lp_err = 1'b0;
    rot_advance = 1'b0;
    if (logical) begin
      if (mode == DM_LOWPRI) begin
        if (hits != '0) begin
          targets     = pick_nth(lmatch, rot_slot(rot_cnt, hits));
          rot_advance = 1'b1;
        end
      end else begin
        targets = lmatch;
      end
    end else begin
      targets     = pmatch;
      phys_lp_err = (mode == DM_LOWPRI);
    end
  end
endmodule

// File: rtl/irq_msg_router.sv
module irq_msg_router
  import irq_route_pkg::*;
#(
  parameter int NUM_PINS = 24,
  localparam int PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_PINS-1:0]         irq_pins,
  input  logic [NUM_PINS*ENTRY_W-1:0] route_tbl,
  input  logic [AGENTS*DEST_W-1:0]    agent_ldest,
  input  logic [VEC_W-1:0]            ext_vector,
  input  logic                        msg_ready,
  output logic                        msg_valid,
  output logic [AGENTS-1:0]           msg_targets,
  output logic [VEC_W-1:0]            msg_vector,
  output logic [2:0]                  msg_mode,
  output logic                        msg_logical,
  output logic                        msg_level,
  output logic                        msg_trigger,
  output logic [DEST_W-1:0]           msg_dest,
  output logic                        lp_err
);
  route_entry_t        ents [NUM_PINS];
  logic [NUM_PINS-1:0] mask_bits;
  logic [NUM_PINS-1:0] pin_rise;
  logic [NUM_PINS-1:0] pending;
  logic [NUM_PINS-1:0] sel_onehot;
  logic [NUM_PINS-1:0] clear_vec;
  logic                sel_any;
  logic [PIN_W-1:0]    sel_idx;
  route_entry_t        sel_ent;
  logic [AGENTS-1:0]   res_targets;
  logic                res_err;
  logic                res_adv;
  logic                slot_free;
  logic                issue;
  logic [ROT_W-1:0]    rot_q;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_ent
    assign ents[g]      = route_entry_t'(route_tbl[g*ENTRY_W +: ENTRY_W]);
    assign mask_bits[g] = ents[g].mask;
  end

  irq_pin_capture #(.NUM_PINS(NUM_PINS)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins      (irq_pins),
    .mask_bits (mask_bits),
    .clear_vec (clear_vec),
    .rise      (pin_rise),
    .pending   (pending)
  );

  irq_pin_select #(.NUM_PINS(NUM_PINS)) u_select (
    .pending (pending),
    .any     (sel_any),
    .idx     (sel_idx),
    .onehot  (sel_onehot)
  );

  assign sel_ent = ents[sel_idx];

  irq_dest_resolve u_resolve (
    .dest        (sel_ent.dest),
    .mode        (sel_ent.mode),
    .logical     (sel_ent.logical),
    .agent_ldest (agent_ldest),
    .rot_cnt     (rot_q),
    .targets     (res_targets),
    .phys_lp_err (res_err),
    .rot_advance (res_adv)
  );

  assign slot_free = ~msg_valid | msg_ready;
  assign issue     = sel_any & slot_free;
  assign clear_vec = issue ? sel_onehot : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      msg_targets <= '0;
      msg_vector  <= '0;
      msg_mode    <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_trigger <= 1'b0;
      msg_dest    <= '0;
      lp_err      <= 1'b0;
      rot_q       <= '0;
    end else begin
      lp_err <= issue & res_err;
      if (slot_free) msg_valid <= issue & ~res_err;
      if (issue && !res_err) begin
        msg_targets <= res_targets;
        msg_vector  <= (sel_ent.mode == DM_EXTVEC) ? ext_vector : sel_ent.vector;
        msg_mode    <= sel_ent.mode;
        msg_logical <= sel_ent.logical;
        msg_level   <= sel_ent.level;
        msg_trigger <= sel_ent.trigger;
        msg_dest    <= sel_ent.dest;
        if (res_adv) rot_q <= rot_q + 1'b1;
      end
    end
  end

  logic unused_rise;
  assign unused_rise = ^pin_rise;
endmodule

// File: rtl/irq_msg_router_chk.sv
module irq_msg_router_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic [7:0] ext_vector,
  input logic       msg_valid,
  input logic       msg_ready,
  input logic [7:0] msg_targets,
  input logic [7:0] msg_vector,
  input logic [2:0] msg_mode,
  input logic       msg_logical,
  input logic [7:0] msg_dest,
  input logic       lp_err
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_targets) &&
                                  $stable(msg_vector) && $stable(msg_dest)));

  p_extvec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (!msg_valid || msg_mode != 3'b111 || msg_vector == $past(ext_vector)));

  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_mode == 3'b001) |-> $onehot0(msg_targets));

  p_no_phys_lp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !(msg_mode == 3'b001 && !msg_logical));

  p_err_nomsg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_err |-> !msg_valid);

  p_bcast_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_logical && msg_dest == 8'hFF) |-> (&msg_targets));
endmodule

bind irq_msg_router irq_msg_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue       (issue),
  .ext_vector  (ext_vector),
  .msg_valid   (msg_valid),
  .msg_ready   (msg_ready),
  .msg_targets (msg_targets),
  .msg_vector  (msg_vector),
  .msg_mode    (msg_mode),
  .msg_logical (msg_logical),
  .msg_dest    (msg_dest),
  .lp_err      (lp_err)
);

// File: tb/irq_msg_router_test.sv
module irq_msg_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int EW = 23;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   irq_pins = '0;
  logic [NP*EW-1:0] route_tbl = '0;
  logic [63:0]     agent_ldest;
  logic [7:0]      ext_vector = 8'h00;
  logic            msg_ready = 1'b1;
  logic            msg_valid;
  logic [7:0]      msg_targets;
  logic [7:0]      msg_vector;
  logic [2:0]      msg_mode;
  logic            msg_logical;
  logic            msg_level;
  logic            msg_trigger;
  logic [7:0]      msg_dest;
  logic            lp_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int rot_m = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_msg_router #(.NUM_PINS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .route_tbl(route_tbl),
    .agent_ldest(agent_ldest), .ext_vector(ext_vector), .msg_ready(msg_ready),
    .msg_valid(msg_valid), .msg_targets(msg_targets), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_dest(msg_dest), .lp_err(lp_err)
  );

  function automatic logic [7:0] ldest_of(int a);
    return 8'((a * 37 + 5) % 256);
  endfunction

  initial for (int a = 0; a < 8; a++) agent_ldest[a*8 +: 8] = ldest_of(a);

  function automatic logic [22:0] mk(logic [7:0] vec, logic [2:0] mode, logic lg,
                                     logic lvl, logic trg, logic msk, logic [7:0] dst);
    return {dst, msk, trg, lvl, lg, mode, vec};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected targets; advances the bench's own rotation model for lowest priority.
  function automatic logic [7:0] exp_targets(logic [7:0] dst, logic [2:0] mode, logic lg);
    int hit_list[8];
    int n = 0;
    logic [7:0] t = 8'h00;
    if (!lg) begin
      if (dst == 8'hFF) return 8'hFF;
      if (dst < 8) return 8'(1 << dst);
      return 8'h00;
    end
    for (int a = 0; a < 8; a++) begin
      if ((ldest_of(a) & dst) != 0) begin
        hit_list[n] = a;
        n++;
        t[a] = 1'b1;
      end
    end
    if (mode != 3'b001) return t;
    if (n == 0) return 8'h00;
    t = 8'(1 << hit_list[rot_m % n]);
    rot_m = (rot_m + 1) % 256;
    return t;
  endfunction

  // Raise one pin with the given entry, check the outcome two edges later.
  task automatic fire(int pin, logic [22:0] ent);
    logic [7:0] et;
    logic [7:0] ev;
    @(negedge clk);
    route_tbl[pin*EW +: EW] = ent;
    ext_vector = 8'(8'hA5 ^ (checks * 7));
    irq_pins[pin] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    if (ent[14]) begin
      chk("R2 masked valid", {31'd0, msg_valid}, 0);
      chk("R2 masked err", {31'd0, lp_err}, 0);
    end else if (ent[10:8] == 3'b001 && !ent[11]) begin
      chk("R8 err pulse", {31'd0, lp_err}, 1);
      chk("R8 no message", {31'd0, msg_valid}, 0);
      @(posedge clk);
      #1;
      chk("R8 err one cycle", {31'd0, lp_err}, 0);
    end else begin
      et = exp_targets(ent[22:15], ent[10:8], ent[11]);
      ev = (ent[10:8] == 3'b111) ? ext_vector : ent[7:0];
      chk("R10 valid", {31'd0, msg_valid}, 1);
      if (!ent[11]) chk("R5 targets", {24'd0, msg_targets}, {24'd0, et});
      else if (ent[10:8] == 3'b001) chk("R7 targets", {24'd0, msg_targets}, {24'd0, et});
      else chk("R6 targets", {24'd0, msg_targets}, {24'd0, et});
      chk("R3 vector", {24'd0, msg_vector}, {24'd0, ev});
      chk("R4 fields", {8'd0, msg_dest, 5'd0, msg_mode, 7'd0, msg_logical, 2'd0, msg_level, msg_trigger},
          {8'd0, ent[22:15], 5'd0, ent[10:8], 7'd0, ent[11], 2'd0, ent[12], ent[13]});
    end
    @(negedge clk);
    irq_pins[pin] = 1'b0;
    @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] dlist [7];
    logic [2:0] mlist [3];
    dlist = '{8'h00, 8'h03, 8'h07, 8'h08, 8'hFF, 8'h81, 8'h5A};
    mlist = '{3'b000, 3'b111, 3'b100};
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset valid", {31'd0, msg_valid}, 0);
    chk("R11 reset err", {31'd0, lp_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep pins, addressing modes, delivery modes, destinations (R4, R5, R6, R3).
    for (int p = 0; p < NP; p++)
      for (int d = 0; d < 7; d++)
        for (int lg = 0; lg < 2; lg++)
          for (int m = 0; m < 3; m++)
            fire(p, mk(8'(16*p + d + 3*m), mlist[m], 1'(lg), 1'(d), 1'(p), 1'b0, dlist[d]));

    // Lowest priority rotation through the counter wrap, incl. no-match (R7, R11).
    for (int i = 0; i < 300; i++)
      fire(i % NP, mk(8'(i), 3'b001, 1'b1, 1'b0, 1'b1, 1'b0,
                      (i % 11 == 0) ? 8'h00 : 8'((i * 29) | 8'h01)));

    // Physical lowest priority is an error (R8), then rotation still consistent.
    fire(2, mk(8'h44, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02));
    fire(0, mk(8'h45, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF));

    // Masked entries (R2).
    for (int p = 0; p < NP; p++)
      fire(p, mk(8'h60, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF));

    // Held pin gives one event, re-arms after low (R1).
    @(negedge clk);
    route_tbl[1*EW +: EW] = mk(8'h71, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01);
    irq_pins[1] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 first event", {31'd0, msg_valid}, 1);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      chk("R1 held no repeat", {31'd0, msg_valid}, 0);
    end
    @(negedge clk); irq_pins[1] = 1'b0;
    @(negedge clk); irq_pins[1] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R1 re-armed", {31'd0, msg_valid}, 1);
    @(negedge clk); irq_pins[1] = 1'b0;
    @(posedge clk);

    // Simultaneous rises, lowest pin first (R9).
    @(negedge clk);
    route_tbl[1*EW +: EW] = mk(8'h31, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02);
    route_tbl[3*EW +: EW] = mk(8'h33, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02);
    irq_pins[1] = 1'b1; irq_pins[3] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 first vector", {24'd0, msg_vector}, 32'h31);
    @(posedge clk); #1;
    chk("R9 second valid", {31'd0, msg_valid}, 1);
    chk("R9 second vector", {24'd0, msg_vector}, 32'h33);
    @(posedge clk); #1;
    chk("R9 drained", {31'd0, msg_valid}, 0);
    @(negedge clk); irq_pins[1] = 1'b0; irq_pins[3] = 1'b0;
    @(posedge clk);

    // Backpressure holds the message, later event waits (R10).
    @(negedge clk);
    msg_ready = 1'b0;
    route_tbl[2*EW +: EW] = mk(8'h52, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h05);
    route_tbl[0*EW +: EW] = mk(8'h50, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h06);
    irq_pins[2] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R10 stalled valid", {31'd0, msg_valid}, 1);
    @(negedge clk); irq_pins[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R10 hold vector", {24'd0, msg_vector}, 32'h52);
      chk("R10 hold targets", {24'd0, msg_targets}, 32'h20);
    end
    @(negedge clk); msg_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 next valid", {31'd0, msg_valid}, 1);
    chk("R10 next vector", {24'd0, msg_vector}, 32'h50);
    @(posedge clk); #1;
    chk("R10 drained", {31'd0, msg_valid}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule